// File: doc/BRIEF.md
# Program Sequencer with Interrupt

This block is the program-flow unit of a small 8-bit soft processor. It owns a 10-bit program counter, a return-address stack, the interrupt-enable state and a saved copy of the ZERO and CARRY flags. The surrounding core presents one decoded flow request for each instruction that finishes, along with the live flags. The sequencer answers with the address of the next instruction to fetch. The ALU, register file and instruction memory are outside the block.

An interrupt is accepted only at an instruction boundary and only while interrupts are armed. Accepting one is a forced call to the highest program address. It saves the flags, masks further interrupts and raises a one-cycle acknowledge. The instruction that was pre-empted is discarded, and its own address is pushed so that it runs again later. A dedicated return-from-interrupt pops that address, presents the saved flags for the core to reload, and chooses whether interrupts are armed afterwards.

The interrupt-enable bit is a two-state machine. MASKED is the reset state. The transition ARM (enable op, or return-from-interrupt with re-enable set) goes from MASKED to ARMED. DISARM (disable op, or return-from-interrupt with re-enable clear) goes from ARMED to MASKED. ACCEPT (request seen at a boundary while ARMED) also goes from ARMED to MASKED. Every other input leaves the state where it is.

Top module: `prog_seq`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 000, selects MASKED (int_en low), clears the acknowledge, flag-load and stack error outputs, and empties the return stack with all slots zeroed.
- R2: The counter changes only in a cycle where step_en is high. A sequential step (flow_op 0) adds one, so 3FF wraps to 000. While step_en is low the counter holds, whatever the other inputs are.
- R3: flow_op 1 is a jump to the absolute target when the condition holds. Condition codes: 0 always, 1 ZERO set, 2 ZERO clear, 3 CARRY set, 4 CARRY clear, 5 to 7 always. When the condition fails, the counter advances by one.
- R4: flow_op 2 (call) pushes counter+1 and loads the target when its condition holds. flow_op 3 (return) pops the top entry into the counter when its condition holds. A failed call or return just advances the counter and leaves the stack unchanged.
- R5: The stack keeps 31 return addresses in a circular store. A push made with 31 entries held overwrites the oldest entry, and a pop made when empty returns whatever the wrapped slot holds. Either event sets stack_err, which stays set until reset.
- R6: While MASKED, irq has no effect: the op is executed and irq_ack stays low.
- R7: flow_op 5 arms interrupts and flow_op 6 masks them. Both advance the counter by one.
- R8: With irq high at a step while ARMED, the op is discarded. The counter goes to 3FF, the address of the pre-empted instruction is pushed, the state becomes MASKED, and irq_ack is high for exactly the next cycle.
- R9: An accepted interrupt saves zero_in and carry_in. flow_op 4 (return-from-interrupt) pops the counter, drives flag_load high for one cycle with the saved flags on zero_rst and carry_rst, and sets the state to ARMED if reti_ie is high and to MASKED otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | An instruction finishes this cycle; the request is valid |
| flow_op | input | 3 | Flow request code (0 step, 1 jump, 2 call, 3 return, 4 return-from-interrupt, 5 arm, 6 mask) |
| cond_sel | input | 3 | Condition code for jump, call and return |
| target | input | 10 | Absolute target address |
| reti_ie | input | 1 | Interrupt state chosen by return-from-interrupt |
| zero_in | input | 1 | Current ZERO flag |
| carry_in | input | 1 | Current CARRY flag |
| irq | input | 1 | Interrupt request |
| pc | output | 10 | Address of the next instruction |
| irq_ack | output | 1 | One-cycle acknowledge of an accepted interrupt |
| int_en | output | 1 | High in state ARMED |
| flag_load | output | 1 | One-cycle strobe: reload flags from zero_rst and carry_rst |
| zero_rst | output | 1 | Saved ZERO flag |
| carry_rst | output | 1 | Saved CARRY flag |
| stack_err | output | 1 | Sticky stack overflow or underflow |

## Verification
The assertions check the following on every cycle:
- the counter stays still when no step is given;
- an acknowledge always lands on address 3FF with interrupts masked, and lasts a single cycle;
- an acknowledge and a flag reload never occur together;
- the stack error never clears without reset and is raised by any push into a full stack.

Only the bench's scenarios can show the rest:
- that the right return address comes back after nested calls and after an interrupt;
- that each condition code picks the correct path;
- that a masked request is ignored;
- that the flags saved on entry are the ones presented on return.

A behavioural model in the bench, with its own stack array, follows a long pseudo-random op stream and is compared on every clock.

// File: rtl/seq_pkg.sv
package seq_pkg;
    typedef enum logic [2:0] {
        OP_STEP   = 3'd0,
        OP_JUMP   = 3'd1,
        OP_CALL   = 3'd2,
        OP_RET    = 3'd3,
        OP_RETI   = 3'd4,
        OP_ARM    = 3'd5,
        OP_MASK   = 3'd6,
        OP_SPARE  = 3'd7
    } seq_op_e;

    typedef enum logic [2:0] {
        CC_ALWAYS = 3'd0,
        CC_Z      = 3'd1,
        CC_NZ     = 3'd2,
        CC_C      = 3'd3,
        CC_NC     = 3'd4
    } seq_cc_e;

    typedef enum logic {
        IE_MASKED = 1'b0,
        IE_ARMED  = 1'b1
    } ie_state_e;
endpackage

// File: rtl/seq_cond_eval.sv
module seq_cond_eval
    import seq_pkg::*;
(
    input  logic [2:0] cond_sel,
    input  logic       zero_in,
    input  logic       carry_in,
    output logic       take
);
    always_comb begin
        unique case (cond_sel)
            CC_Z:    take = zero_in;
            CC_NZ:   take = !zero_in;
            CC_C:    take = carry_in;
            CC_NC:   take = !carry_in;
            default: take = 1'b1;
        endcase
    end
endmodule

// File: rtl/seq_ret_stack.sv
module seq_ret_stack #(
    parameter int DEPTH = 31,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] rdata,
    output logic          err
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [AW-1:0] slots [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] top_ptr;
    logic [PW-1:0] nxt_ptr;
    logic [CW-1:0] fill;

    assign top_ptr = (wr_ptr == '0) ? LAST : wr_ptr - PW'(1);
    assign nxt_ptr = (wr_ptr == LAST) ? '0 : wr_ptr + PW'(1);
    assign rdata   = slots[top_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= '0;
            end
            wr_ptr <= '0;
            fill   <= '0;
            err    <= 1'b0;
        end else if (push) begin
            slots[wr_ptr] <= wdata;
            wr_ptr        <= nxt_ptr;
            if (fill == FULL) begin
                err <= 1'b1;
            end else begin
                fill <= fill + CW'(1);
            end
        end else if (pop) begin
            wr_ptr <= top_ptr;
            if (fill == '0) begin
                err <= 1'b1;
            end else begin
                fill <= fill - CW'(1);
            end
        end
    end

    // R5: the error indication is sticky
    a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
        err |=> err);
    // R5: a push into a full store raises the error
    a_r5_full_push: assert property (@(posedge clk) disable iff (rst)
        (push && fill == FULL) |=> err);
    // R5: a pop from an empty store raises the error
    a_r5_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && fill == '0) |=> err);
endmodule

// File: rtl/prog_seq.sv
module prog_seq
    import seq_pkg::*;
#(
    parameter int PC_W      = 10,
    parameter int STK_DEPTH = 31
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step_en,
    input  logic [2:0]      flow_op,
    input  logic [2:0]      cond_sel,
    input  logic [PC_W-1:0] target,
    input  logic            reti_ie,
    input  logic            zero_in,
    input  logic            carry_in,
    input  logic            irq,
    output logic [PC_W-1:0] pc,
    output logic            irq_ack,
    output logic            int_en,
    output logic            flag_load,
    output logic            zero_rst,
    output logic            carry_rst,
    output logic            stack_err
);
    localparam logic [PC_W-1:0] VECTOR = '1;
    localparam logic [PC_W-1:0] ONE    = PC_W'(1);

    ie_state_e       ie_q, ie_d;
    seq_op_e         op;
    logic            take;
    logic            accept;
    logic            push, pop;
    logic [PC_W-1:0] push_data, pop_data, pc_d;
    logic            reti_exec;

    assign op     = seq_op_e'(flow_op);
    assign accept = step_en && (ie_q == IE_ARMED) && irq;
    assign int_en = (ie_q == IE_ARMED);

    seq_cond_eval u_cond (
        .cond_sel (cond_sel),
        .zero_in  (zero_in),
        .carry_in (carry_in),
        .take     (take)
    );

    seq_ret_stack #(.DEPTH(STK_DEPTH), .AW(PC_W)) u_stack (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .wdata (push_data),
        .rdata (pop_data),
        .err   (stack_err)
    );

    // Next-state and next-address logic
    always_comb begin
        ie_d      = ie_q;
        pc_d      = pc;
        push      = 1'b0;
        pop       = 1'b0;
        push_data = pc + ONE;
        reti_exec = 1'b0;
        if (step_en) begin
            if (accept) begin
                push      = 1'b1;
                push_data = pc;
                pc_d      = VECTOR;
                ie_d      = IE_MASKED;
            end else begin
                pc_d = pc + ONE;
                unique case (op)
                    OP_JUMP: if (take) pc_d = target;
                    OP_CALL: if (take) begin
                        push = 1'b1;
                        pc_d = target;
                    end
                    OP_RET: if (take) begin
                        pop  = 1'b1;
                        pc_d = pop_data;
                    end
                    OP_RETI: begin
                        pop       = 1'b1;
                        pc_d      = pop_data;
                        reti_exec = 1'b1;
                        ie_d      = reti_ie ? IE_ARMED : IE_MASKED;
                    end
                    OP_ARM:  ie_d = IE_ARMED;
                    OP_MASK: ie_d = IE_MASKED;
                    default: ;
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q <= IE_MASKED;
        end else begin
            ie_q <= ie_d;
        end
    end

    // Output registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc        <= '0;
            irq_ack   <= 1'b0;
            flag_load <= 1'b0;
            zero_rst  <= 1'b0;
            carry_rst <= 1'b0;
        end else begin
            pc        <= pc_d;
            irq_ack   <= accept;
            flag_load <= reti_exec;
            if (accept) begin
                zero_rst  <= zero_in;
                carry_rst <= carry_in;
            end
        end
    end

    // R2: no step, no movement
    a_r2_hold_pc: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(pc));
    // R8: acknowledge coincides with the vector address
    a_r8_ack_vector: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> (pc == VECTOR));
    // R8: acknowledge comes with interrupts masked
    a_r8_ack_masked: assert property (@(posedge clk) disable iff (rst)
        irq_ack |-> !int_en);
    // R8: acknowledge is a single-cycle pulse
    a_r8_ack_single: assert property (@(posedge clk) disable iff (rst)
        irq_ack |=> !irq_ack);
    // R9: reload strobe and acknowledge never overlap
    a_r9_load_vs_ack: assert property (@(posedge clk) disable iff (rst)
        !(flag_load && irq_ack));
endmodule

// File: tb/prog_seq_bench.sv
module prog_seq_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_en = 1'b0;
    logic [2:0] flow_op = 3'd0;
    logic [2:0] cond_sel = 3'd0;
    logic [9:0] target = 10'd0;
    logic       reti_ie = 1'b0;
    logic       zero_in = 1'b0;
    logic       carry_in = 1'b0;
    logic       irq = 1'b0;
    logic [9:0] pc;
    logic       irq_ack, int_en, flag_load, zero_rst, carry_rst, stack_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit live = 0;
    bit done = 0;

    always #2 clk = ~clk;

    prog_seq u_prog_seq (
        .clk(clk), .rst(rst), .step_en(step_en), .flow_op(flow_op),
        .cond_sel(cond_sel), .target(target), .reti_ie(reti_ie),
        .zero_in(zero_in), .carry_in(carry_in), .irq(irq), .pc(pc),
        .irq_ack(irq_ack), .int_en(int_en), .flag_load(flag_load),
        .zero_rst(zero_rst), .carry_rst(carry_rst), .stack_err(stack_err)
    );

    // Behavioural reference model
    int m_stk [31];
    int m_ptr, m_cnt, m_pc;
    bit m_ie, m_ack, m_fl, m_z, m_c, m_err;

    function automatic bit cond_ok(int cd, bit z, bit c);
        case (cd)
            1: return z;
            2: return !z;
            3: return c;
            4: return !c;
            default: return 1'b1;
        endcase
    endfunction

    task automatic m_push(int v);
        m_stk[m_ptr] = v;
        m_ptr = (m_ptr + 1) % 31;
        if (m_cnt == 31) m_err = 1; else m_cnt++;
    endtask

    task automatic m_pop(output int v);
        if (m_cnt == 0) m_err = 1; else m_cnt--;
        m_ptr = (m_ptr + 30) % 31;
        v = m_stk[m_ptr];
    endtask

    always @(posedge clk) begin
        int v;
        if (rst) begin
            foreach (m_stk[i]) m_stk[i] = 0;
            m_ptr = 0; m_cnt = 0; m_pc = 0; m_ie = 0;
            m_ack = 0; m_fl = 0; m_z = 0; m_c = 0; m_err = 0;
            live = 1;
        end else begin
            m_ack = 0;
            m_fl  = 0;
            if (step_en) begin
                if (m_ie && irq) begin
                    m_push(m_pc);
                    m_pc = 10'h3FF; m_ie = 0; m_z = zero_in; m_c = carry_in; m_ack = 1;
                end else begin
                    bit t;
                    t = cond_ok(int'(cond_sel), zero_in, carry_in);
                    case (int'(flow_op))
                        1: m_pc = t ? int'(target) : (m_pc + 1) % 1024;
                        2: if (t) begin m_push((m_pc + 1) % 1024); m_pc = int'(target); end
                           else m_pc = (m_pc + 1) % 1024;
                        3: if (t) begin m_pop(v); m_pc = v; end
                           else m_pc = (m_pc + 1) % 1024;
                        4: begin m_pop(v); m_pc = v; m_fl = 1; m_ie = reti_ie; end
                        5: begin m_ie = 1; m_pc = (m_pc + 1) % 1024; end
                        6: begin m_ie = 0; m_pc = (m_pc + 1) % 1024; end
                        default: m_pc = (m_pc + 1) % 1024;
                    endcase
                end
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (live && !rst && !done) begin
            chk("R3 pc", int'(pc), m_pc);
            chk("R7 int_en", int'(int_en), int'(m_ie));
            chk("R8 irq_ack", int'(irq_ack), int'(m_ack));
            chk("R9 flag_load", int'(flag_load), int'(m_fl));
            if (m_fl) begin
                chk("R9 zero_rst", int'(zero_rst), int'(m_z));
                chk("R9 carry_rst", int'(carry_rst), int'(m_c));
            end
            chk("R5 stack_err", int'(stack_err), int'(m_err));
        end
    end

    task automatic drive(bit st, int op, int cd, int tg, bit rq, bit z, bit c, bit rie);
        step_en = st; flow_op = 3'(op); cond_sel = 3'(cd); target = 10'(tg);
        irq = rq; zero_in = z; carry_in = c; reti_ie = rie;
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        chk("R1 pc", int'(pc), 0);
        chk("R1 int_en", int'(int_en), 0);
        chk("R1 ack", int'(irq_ack), 0);
        chk("R1 flag_load", int'(flag_load), 0);
        chk("R1 stack_err", int'(stack_err), 0);
        drive(0, 1, 0, 'h55, 1, 0, 0, 0);   chk("R2 hold", int'(pc), 0);
        drive(1, 0, 0, 0, 0, 0, 0, 0);      chk("R2 step", int'(pc), 1);
        drive(1, 1, 0, 'h100, 0, 0, 0, 0);  chk("R3 jump always", int'(pc), 'h100);
        drive(1, 1, 1, 'h200, 0, 0, 0, 0);  chk("R3 jump Z fail", int'(pc), 'h101);
        drive(1, 1, 2, 'h200, 0, 0, 0, 0);  chk("R3 jump NZ", int'(pc), 'h200);
        drive(1, 1, 3, 'h3FF, 0, 0, 1, 0);  chk("R3 jump C", int'(pc), 'h3FF);
        drive(1, 0, 0, 0, 0, 0, 0, 0);      chk("R2 wrap", int'(pc), 0);
        drive(1, 2, 0, 'h040, 0, 0, 0, 0);  chk("R4 call", int'(pc), 'h040);
        drive(1, 3, 0, 0, 0, 0, 0, 0);      chk("R4 return", int'(pc), 1);
        drive(1, 3, 4, 0, 0, 0, 1, 0);      chk("R4 failed return", int'(pc), 2);
        drive(1, 0, 0, 0, 1, 0, 0, 0);      chk("R6 masked pc", int'(pc), 3);
        chk("R6 masked ack", int'(irq_ack), 0);
        drive(1, 5, 0, 0, 0, 0, 0, 0);      chk("R7 arm", int'(int_en), 1);
        drive(1, 1, 0, 'h123, 1, 1, 0, 0);  chk("R8 vector", int'(pc), 'h3FF);
        chk("R8 ack", int'(irq_ack), 1);
        chk("R8 masked", int'(int_en), 0);
        drive(1, 0, 0, 0, 1, 0, 1, 0);      chk("R8 ack single", int'(irq_ack), 0);
        drive(1, 4, 0, 0, 0, 0, 1, 1);      chk("R9 resume pc", int'(pc), 4);
        chk("R9 load", int'(flag_load), 1);
        chk("R9 zero", int'(zero_rst), 1);
        chk("R9 carry", int'(carry_rst), 0);
        chk("R9 rearm", int'(int_en), 1);
        drive(1, 6, 0, 0, 0, 0, 0, 0);      chk("R7 mask", int'(int_en), 0);
        for (int i = 0; i < 31; i++) drive(1, 2, 0, 'h010, 0, 0, 0, 0);
        chk("R5 full no err", int'(stack_err), 0);
        drive(1, 2, 0, 'h010, 0, 0, 0, 0);  chk("R5 overflow", int'(stack_err), 1);
        drive(1, 3, 0, 0, 0, 0, 0, 0);      chk("R5 sticky", int'(stack_err), 1);
        rst = 1'b1; drive(0, 0, 0, 0, 0, 0, 0, 0); rst = 1'b0;
        chk("R1 err cleared", int'(stack_err), 0);
        drive(1, 3, 0, 0, 0, 0, 0, 0);      chk("R5 underflow", int'(stack_err), 1);
        chk("R5 underflow pc", int'(pc), 0);
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            drive(r < 80, $urandom_range(0, 7), $urandom_range(0, 7),
                  $urandom_range(0, 1023), $urandom_range(0, 9) == 0,
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  1'($urandom_range(0, 1)));
        end
        finish_run();
    end
endmodule